// File: doc/BRIEF.md
# Burst-of-Two Quad-Data-Rate Static Memory Model

This block is a synthesizable stand-in for a quad-data-rate static memory. It has one read port and one write port that work at the same time, and one address bus that the two ports share. It runs on a single clock, `clk2x`, with one rising edge for every edge of the memory's input clock pair. An internal phase flop sets the phase: after reset, the first `clk2x` edge is a K-rise tick and the next is a K-bar tick, and the two alternate from then on. Every access moves two words of `DATA_W` bits, one word on each tick of a K cycle. The storage is two banks of equal depth. A burst address selects a word pair: beat 0 is the bank-0 word and beat 1 is the bank-1 word at the same index.

A write is requested on a K-rise tick. On that tick the block captures the first data word and its byte mask. On the following K-bar tick it captures the write address, the second word and its mask, and both words are committed on that edge. A read is requested on a K-rise tick together with its address. The two words come out on `q` in consecutive ticks, starting `RD_LAT_TICKS` ticks after the request edge. The default is 3 ticks, which is 1.5 clock cycles. `q_valid` marks the two beats for the core side, and `q_oe` enables the pad driver. Between bursts `q` is held at zero.

There is no back-pressure at either port. Every selected command is accepted on its tick. Read data appears at a fixed latency, and the consumer must be ready for it.

Top module: `qdr_burst2_sram`

## Requirements
- R1: After reset, `q`, `q_valid` and `q_oe` are zero, and every word in both banks reads back as zero.
- R2: The first `clk2x` edge after reset release is a K-rise tick, and ticks alternate K-rise, K-bar from then on. A low `rps_n` seen only on a K-bar tick starts no read.
- R3: A read starts only when `rps_n` is low on a K-rise tick, and `addr` is captured as the read address on that tick. When `rps_n` is high, `addr` has no effect on the read side and no output beat appears.
- R4: A write starts when `wps_n` is low on a K-rise tick. That tick supplies `d` and `bws_n` for beat 0. The next K-bar tick supplies the write address, `d` and `bws_n` for beat 1. When `wps_n` is high on the K-rise tick, nothing is stored, whatever `d`, `addr` and `bws_n` carry.
- R5: `bws_n` is active low and qualifies the data word sampled on the same tick. Bit 0 gates `d[8:0]` and bit 1 gates `d[17:9]`. A disabled byte keeps its stored value.
- R6: Write beat 0 goes to bank 0 and beat 1 goes to bank 1, both at the write address. A read returns bank 0 at the read address first, then bank 1.
- R7: The first read beat is on `q` after edge t0+`RD_LAT_TICKS` and the second beat after the next edge, where t0 is the request edge. `q_valid` and `q_oe` are high on exactly those ticks.
- R8: A read reflects every enabled byte written by a write that started in the same K cycle or an earlier one. It does not reflect writes that start in later cycles.
- R9: When no beat is due, `q_oe` and `q_valid` fall on the tick after the last beat, and `q` reads zero.
- R10: Reads issued in consecutive K cycles produce an unbroken stream of beats, two per request, in request order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk2x | input | 1 | One rising edge per K or K-bar edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| rps_n | input | 1 | Read request, active low, sampled on K-rise ticks |
| wps_n | input | 1 | Write request, active low, sampled on K-rise ticks |
| addr | input | ADDR_W | Shared address: read address on K-rise ticks, write address on K-bar ticks |
| bws_n | input | DATA_W/BYTE_W | Active-low byte enables for the data word on the same tick |
| d | input | DATA_W | Write data, one word per tick of a write burst |
| q | output | DATA_W | Read data, one word per tick of a read burst, zero otherwise |
| q_oe | output | 1 | Pad driver enable for `q` |
| q_valid | output | 1 | Marks the ticks on which `q` carries a read beat |

## Verification
A write commit and a read snapshot can land on the same word pair within one K cycle. The write commits on the K-bar tick, and the read request from the same K-rise tick takes its snapshot on the next K-rise tick. Directed cycles issue a read and a byte-masked write to the same address in the same cycle. Random cycles cause many more same-cycle and next-cycle collisions. A bench reference array applies each write before taking that cycle's read snapshot, so same-cycle writes show in the expected beats and later writes do not. Every tick is compared against this per-tick schedule.

// File: rtl/qdr_pkg.sv
package qdr_pkg;
  // Which edge of the K clock pair the current clk2x tick stands for.
  typedef enum logic {
    EDGE_KBAR = 1'b0,
    EDGE_K    = 1'b1
  } kedge_e;
endpackage

// File: rtl/qdr_cmd_capture.sv
module qdr_cmd_capture
  import qdr_pkg::*;
#(
  parameter int AW = 4,
  parameter int DW = 18,
  parameter int NB = 2
) (
  input  logic          clk2x,
  input  logic          rst_n,
  input  logic          rps_n,
  input  logic          wps_n,
  input  logic [AW-1:0] addr,
  input  logic [NB-1:0] bws_n,
  input  logic [DW-1:0] d,
  output logic          wr_go,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_d0,
  output logic [DW-1:0] wr_d1,
  output logic [NB-1:0] wr_be0,
  output logic [NB-1:0] wr_be1,
  output logic          rd_go,
  output logic [AW-1:0] rd_addr
);
  kedge_e cur_edge;
  logic   wr_arm;
  logic   rd_arm;

  always_ff @(posedge clk2x or negedge rst_n) begin
    if (!rst_n) cur_edge <= EDGE_K;
    else        cur_edge <= (cur_edge == EDGE_K) ? EDGE_KBAR : EDGE_K;
  end

  // Commands, read address and first write beat live on K-rise ticks.
  always_ff @(posedge clk2x or negedge rst_n) begin
    if (!rst_n) begin
      wr_arm  <= 1'b0;
      rd_arm  <= 1'b0;
      wr_d0   <= '0;
      wr_be0  <= '0;
      rd_addr <= '0;
    end else if (cur_edge == EDGE_K) begin
      wr_arm <= !wps_n;
      rd_arm <= !rps_n;
      if (!wps_n) begin
        wr_d0  <= d;
        wr_be0 <= ~bws_n;
      end
      if (!rps_n) rd_addr <= addr;
    end
  end

  // Second write beat and write address are taken straight from the pins.
  assign wr_go   = (cur_edge == EDGE_KBAR) && wr_arm;
  assign wr_addr = addr;
  assign wr_d1   = d;
  assign wr_be1  = ~bws_n;
  // The read snapshot is due on the K-rise tick after the request.
  assign rd_go   = (cur_edge == EDGE_K) && rd_arm;
endmodule

// File: rtl/qdr_bank_pair.sv
module qdr_bank_pair #(
  parameter int AW = 4,
  parameter int DW = 18,
  parameter int NB = 2
) (
  input  logic          clk2x,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wd0,
  input  logic [DW-1:0] wd1,
  input  logic [NB-1:0] be0,
  input  logic [NB-1:0] be1,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd0,
  output logic [DW-1:0] rd1
);
  localparam int DEPTH = 1 << AW;
  localparam int BW    = DW / NB;

  logic [1:0][DW-1:0] wd;
  logic [1:0][NB-1:0] be;
  logic [1:0][DW-1:0] rd;

  assign wd  = {wd1, wd0};
  assign be  = {be1, be0};
  assign rd0 = rd[0];
  assign rd1 = rd[1];

  for (genvar g = 0; g < 2; g++) begin : gen_bank
    logic [DW-1:0] cells [DEPTH];

    always_ff @(posedge clk2x or negedge rst_n) begin
      if (!rst_n) begin
        for (int i = 0; i < DEPTH; i++) cells[i] <= '0;
      end else if (wr_en) begin
        for (int b = 0; b < NB; b++) begin
          if (be[g][b]) cells[wr_addr][b*BW +: BW] <= wd[g][b*BW +: BW];
        end
      end
    end

    assign rd[g] = cells[rd_addr];
  end
endmodule

// File: rtl/qdr_read_out.sv
module qdr_read_out #(
  parameter int DW  = 18,
  parameter int LAT = 3
) (
  input  logic          clk2x,
  input  logic          rst_n,
  input  logic          snap_go,
  input  logic [DW-1:0] snap0,
  input  logic [DW-1:0] snap1,
  output logic [DW-1:0] q,
  output logic          q_oe,
  output logic          q_valid
);
  // The snapshot is taken two ticks after the request edge; the rest of
  // the latency is a delay line of whole ticks.
  localparam int DLY = LAT - 2;

  logic          head_v;
  logic [DW-1:0] head0;
  logic [DW-1:0] head1;

  if (DLY == 0) begin : gen_direct
    assign head_v = snap_go;
    assign head0  = snap0;
    assign head1  = snap1;
  end else begin : gen_delay
    for (genvar s = 0; s < DLY; s++) begin : gen_stage
      logic          v;
      logic [DW-1:0] w0;
      logic [DW-1:0] w1;
      if (s == 0) begin : gen_first
        always_ff @(posedge clk2x or negedge rst_n) begin
          if (!rst_n) begin
            v  <= 1'b0;
            w0 <= '0;
            w1 <= '0;
          end else begin
            v  <= snap_go;
            w0 <= snap0;
            w1 <= snap1;
          end
        end
      end else begin : gen_next
        always_ff @(posedge clk2x or negedge rst_n) begin
          if (!rst_n) begin
            v  <= 1'b0;
            w0 <= '0;
            w1 <= '0;
          end else begin
            v  <= gen_stage[s-1].v;
            w0 <= gen_stage[s-1].w0;
            w1 <= gen_stage[s-1].w1;
          end
        end
      end
    end
    assign head_v = gen_stage[DLY-1].v;
    assign head0  = gen_stage[DLY-1].w0;
    assign head1  = gen_stage[DLY-1].w1;
  end

  logic          beat1_due;
  logic [DW-1:0] beat1_word;
  logic [DW-1:0] q_r;
  logic          valid_r;
  logic          oe_r;

  always_ff @(posedge clk2x or negedge rst_n) begin
    if (!rst_n) begin
      q_r        <= '0;
      valid_r    <= 1'b0;
      oe_r       <= 1'b0;
      beat1_due  <= 1'b0;
      beat1_word <= '0;
    end else if (head_v) begin
      q_r        <= head0;
      valid_r    <= 1'b1;
      oe_r       <= 1'b1;
      beat1_due  <= 1'b1;
      beat1_word <= head1;
    end else if (beat1_due) begin
      q_r       <= beat1_word;
      valid_r   <= 1'b1;
      oe_r      <= 1'b1;
      beat1_due <= 1'b0;
    end else begin
      q_r     <= '0;
      valid_r <= 1'b0;
      oe_r    <= 1'b0;
    end
  end

  assign q       = q_r;
  assign q_valid = valid_r;
  assign q_oe    = oe_r;
endmodule

// File: rtl/qdr_burst2_sram.sv
module qdr_burst2_sram #(
  parameter int ADDR_W       = 4,
  parameter int DATA_W       = 18,
  parameter int BYTE_W       = 9,
  parameter int RD_LAT_TICKS = 3
) (
  input  logic                     clk2x,
  input  logic                     rst_n,
  input  logic                     rps_n,
  input  logic                     wps_n,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [DATA_W/BYTE_W-1:0] bws_n,
  input  logic [DATA_W-1:0]        d,
  output logic [DATA_W-1:0]        q,
  output logic                     q_oe,
  output logic                     q_valid
);
  localparam int NBYTE = DATA_W / BYTE_W;

  logic              wr_go;
  logic [ADDR_W-1:0] wr_addr;
  logic [DATA_W-1:0] wr_d0;
  logic [DATA_W-1:0] wr_d1;
  logic [NBYTE-1:0]  wr_be0;
  logic [NBYTE-1:0]  wr_be1;
  logic              rd_go;
  logic [ADDR_W-1:0] rd_addr;
  logic [DATA_W-1:0] rd0;
  logic [DATA_W-1:0] rd1;

  qdr_cmd_capture #(.AW(ADDR_W), .DW(DATA_W), .NB(NBYTE)) u_cmd (
    .clk2x  (clk2x),
    .rst_n  (rst_n),
    .rps_n  (rps_n),
    .wps_n  (wps_n),
    .addr   (addr),
    .bws_n  (bws_n),
    .d      (d),
    .wr_go  (wr_go),
    .wr_addr(wr_addr),
    .wr_d0  (wr_d0),
    .wr_d1  (wr_d1),
    .wr_be0 (wr_be0),
    .wr_be1 (wr_be1),
    .rd_go  (rd_go),
    .rd_addr(rd_addr)
  );

  qdr_bank_pair #(.AW(ADDR_W), .DW(DATA_W), .NB(NBYTE)) u_banks (
    .clk2x  (clk2x),
    .rst_n  (rst_n),
    .wr_en  (wr_go),
    .wr_addr(wr_addr),
    .wd0    (wr_d0),
    .wd1    (wr_d1),
    .be0    (wr_be0),
    .be1    (wr_be1),
    .rd_addr(rd_addr),
    .rd0    (rd0),
    .rd1    (rd1)
  );

  qdr_read_out #(.DW(DATA_W), .LAT(RD_LAT_TICKS)) u_out (
    .clk2x  (clk2x),
    .rst_n  (rst_n),
    .snap_go(rd_go),
    .snap0  (rd0),
    .snap1  (rd1),
    .q      (q),
    .q_oe   (q_oe),
    .q_valid(q_valid)
  );
endmodule

// File: rtl/qdr_burst2_sram_chk.sv
module qdr_burst2_sram_chk #(
  parameter int DATA_W = 18,
  parameter int LAT    = 3
) (
  input logic              clk2x,
  input logic              rst_n,
  input logic              rps_n,
  input logic [DATA_W-1:0] q,
  input logic              q_oe,
  input logic              q_valid
);
  // Independent phase tracker and request history.
  logic           k_tick;
  logic [LAT+1:0] req_hist;
  logic           beat_odd;

  always_ff @(posedge clk2x or negedge rst_n) begin
    if (!rst_n) begin
      k_tick   <= 1'b1;
      req_hist <= '0;
      beat_odd <= 1'b0;
    end else begin
      k_tick   <= !k_tick;
      req_hist <= {req_hist[LAT:0], k_tick && !rps_n};
      beat_odd <= q_valid ? !beat_odd : 1'b0;
    end
  end

  AST_READ_LATENCY: assert property (@(posedge clk2x) disable iff (!rst_n)
    q_valid == (req_hist[LAT] | req_hist[LAT+1])); // R7

  AST_BURST_PAIR: assert property (@(posedge clk2x) disable iff (!rst_n)
    $rose(q_valid) |=> q_valid); // R10

  AST_EVEN_BEATS: assert property (@(posedge clk2x) disable iff (!rst_n)
    (!q_valid && $past(q_valid)) |-> !beat_odd); // R6

  AST_IDLE_QUIET: assert property (@(posedge clk2x) disable iff (!rst_n)
    !q_oe |-> (q == '0)); // R9
endmodule

bind qdr_burst2_sram qdr_burst2_sram_chk #(.DATA_W(DATA_W), .LAT(RD_LAT_TICKS)) u_chk (
  .clk2x  (clk2x),
  .rst_n  (rst_n),
  .rps_n  (rps_n),
  .q      (q),
  .q_oe   (q_oe),
  .q_valid(q_valid)
);

// File: tb/qdr_burst2_sram_bench.sv
module qdr_burst2_sram_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW    = 4;
  localparam int DW    = 18;
  localparam int LAT   = 3;
  localparam int DEPTH = 1 << AW;
  localparam int NT    = 8192;

  logic          clk2x = 1'b0;
  logic          rst_n = 1'b0;
  logic          rps_n = 1'b1;
  logic          wps_n = 1'b1;
  logic [AW-1:0] addr  = '0;
  logic [1:0]    bws_n = 2'b11;
  logic [DW-1:0] d     = '0;
  logic [DW-1:0] q;
  logic          q_oe;
  logic          q_valid;

  qdr_burst2_sram #(.ADDR_W(AW), .DATA_W(DW), .BYTE_W(9), .RD_LAT_TICKS(LAT)) u_qdr_burst2_sram (
    .clk2x(clk2x), .rst_n(rst_n), .rps_n(rps_n), .wps_n(wps_n), .addr(addr),
    .bws_n(bws_n), .d(d), .q(q), .q_oe(q_oe), .q_valid(q_valid)
  );

  always #(CLK_PERIOD/2) clk2x = ~clk2x;

  logic [DW-1:0] ref0 [DEPTH];
  logic [DW-1:0] ref1 [DEPTH];
  bit            exp_v [NT];
  logic [DW-1:0] exp_q [NT];
  string         exp_tag [NT];
  string         cur_tag = "R1";
  int            tick = 0;
  int            errors = 0;
  int            checks = 0;
  bit            running = 1'b0;
  bit            done = 1'b0;

  function automatic logic [DW-1:0] merge(input logic [DW-1:0] old_w,
                                          input logic [DW-1:0] new_w,
                                          input logic [1:0] en);
    logic [DW-1:0] r;
    r = old_w;
    if (en[0]) r[8:0]  = new_w[8:0];
    if (en[1]) r[17:9] = new_w[17:9];
    return r;
  endfunction

  always @(posedge clk2x) if (rst_n) tick <= tick + 1;

  // Compare every tick against the expected schedule.
  always @(negedge clk2x) begin
    if (rst_n && running && tick > 0 && tick <= NT) begin
      int idx;
      idx = tick - 1;
      checks++;
      if (q_valid !== exp_v[idx] || q_oe !== exp_v[idx]) begin
        errors++;
        $display("FAIL R7 %s tick %0d: valid=%0b oe=%0b expected %0b", cur_tag, idx, q_valid, q_oe, exp_v[idx]);
      end else if (exp_v[idx] && q !== exp_q[idx]) begin
        errors++;
        $display("FAIL %s tick %0d: q=%h expected %h", exp_tag[idx], idx, q, exp_q[idx]);
      end else if (!exp_v[idx] && q !== '0) begin
        errors++;
        $display("FAIL R9 %s tick %0d: idle q=%h expected 0", cur_tag, idx, q);
      end
    end
  end

  // One K cycle: a K-rise tick followed by a K-bar tick.
  task automatic kcycle(input bit rd, input logic [AW-1:0] ra,
                        input bit wr, input logic [AW-1:0] wa,
                        input logic [DW-1:0] d0, input logic [DW-1:0] d1,
                        input logic [1:0] m0, input logic [1:0] m1,
                        input string tag, input bit rd_late = 1'b0);
    int t0;
    t0 = tick;
    if (wr) begin
      ref0[wa] = merge(ref0[wa], d0, m0);
      ref1[wa] = merge(ref1[wa], d1, m1);
    end
    if (rd && t0 + LAT + 1 < NT) begin
      exp_v[t0+LAT]     = 1'b1;
      exp_q[t0+LAT]     = ref0[ra];
      exp_tag[t0+LAT]   = tag;
      exp_v[t0+LAT+1]   = 1'b1;
      exp_q[t0+LAT+1]   = ref1[ra];
      exp_tag[t0+LAT+1] = tag;
    end
    rps_n = !rd;
    wps_n = !wr;
    addr  = ra;
    d     = d0;
    bws_n = ~m0;
    @(posedge clk2x);
    @(negedge clk2x);
    rps_n = !rd_late;
    wps_n = $urandom_range(0, 1);
    addr  = wa;
    d     = d1;
    bws_n = ~m1;
    @(posedge clk2x);
    @(negedge clk2x);
    rps_n = 1'b1;
    wps_n = 1'b1;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    for (int i = 0; i < DEPTH; i++) begin ref0[i] = '0; ref1[i] = '0; end
    for (int i = 0; i < NT; i++) begin exp_v[i] = 1'b0; exp_q[i] = '0; exp_tag[i] = "R6"; end
    repeat (3) @(posedge clk2x);
    @(negedge clk2x);
    checks++;
    if (q !== '0 || q_valid !== 1'b0 || q_oe !== 1'b0) begin
      errors++;
      $display("FAIL R1 reset outputs: q=%h valid=%0b oe=%0b expected 0 0 0", q, q_valid, q_oe);
    end
    rst_n   = 1'b1;
    running = 1'b1;

    // R1: the array is clear after reset.
    cur_tag = "R1";
    for (int a = 0; a < DEPTH; a++) kcycle(1, a, 0, 0, $urandom, $urandom, 2'b11, 2'b11, "R1");

    // R4 and R6: full writes, then read the pairs back.
    cur_tag = "R6";
    for (int a = 0; a < DEPTH; a++) kcycle(0, 0, 1, a, $urandom, $urandom, 2'b11, 2'b11, "R6");
    for (int a = 0; a < DEPTH; a++) kcycle(1, a, 0, 0, 0, 0, 2'b00, 2'b00, "R6");

    // R5: per-beat byte masks.
    cur_tag = "R5";
    for (int a = 0; a < DEPTH; a++)
      kcycle(0, 0, 1, a, $urandom, $urandom, 2'($urandom), 2'($urandom), "R5");
    for (int a = 0; a < DEPTH; a++) kcycle(1, a, 0, 0, 0, 0, 2'b00, 2'b00, "R5");

    // R8: same-cycle write and read of one address, then a write one cycle after a read.
    cur_tag = "R8";
    for (int a = 0; a < DEPTH; a++)
      kcycle(1, a, 1, a, $urandom, $urandom, 2'($urandom), 2'($urandom), "R8");
    for (int a = 0; a < 8; a++) begin
      kcycle(1, a, 0, 0, 0, 0, 2'b00, 2'b00, "R8");
      kcycle(0, 0, 1, a, $urandom, $urandom, 2'b11, 2'b11, "R8");
    end

    // R3 and R4: deselected ports with busy pins leave output and array untouched.
    cur_tag = "R3";
    for (int i = 0; i < 12; i++)
      kcycle(0, 4'($urandom), 0, 4'($urandom), $urandom, $urandom, 2'b00, 2'b00, "R3");
    cur_tag = "R4";
    for (int a = 0; a < DEPTH; a++) kcycle(1, a, 0, 0, $urandom, $urandom, 2'b00, 2'b00, "R4");
    repeat (4) kcycle(0, 0, 0, 0, 0, 0, 2'b00, 2'b00, "R4");

    // R2: a read request that is only present on the K-bar tick is ignored.
    cur_tag = "R2";
    for (int i = 0; i < 8; i++) kcycle(0, 4'(i), 0, 0, 0, 0, 2'b00, 2'b00, "R2", 1'b1);

    // R10: back-to-back reads form an unbroken stream.
    cur_tag = "R10";
    for (int a = DEPTH - 1; a >= 0; a--) kcycle(1, a, 0, 0, 0, 0, 2'b00, 2'b00, "R10");

    // R9: drivers turn off after the last beat.
    cur_tag = "R9";
    repeat (4) kcycle(0, 0, 0, 0, 0, 0, 2'b00, 2'b00, "R9");

    // Random mix of concurrent reads and masked writes (R8).
    cur_tag = "R8";
    for (int i = 0; i < 1100; i++)
      kcycle($urandom_range(0, 1), 4'($urandom), $urandom_range(0, 1), 4'($urandom),
             $urandom, $urandom, 2'($urandom), 2'($urandom), "R8");

    cur_tag = "R9";
    repeat (4) kcycle(0, 0, 0, 0, 0, 0, 2'b00, 2'b00, "R9");
    running = 1'b0;
    done    = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule